// File: doc/BRIEF.md
# ODT Hold-Time Protocol Monitor

This block is a cycle-based monitor that sits beside a DRAM command interface and watches the on-die-termination enable level, as registered on each rising clock edge, together with the write-command strobe and a burst-length select. It enforces the minimum time that ODT must stay high. It does not generate ODT and does not check analog turn-on or turn-off timing.

Two hold windows can be open at the same time. The first window opens when ODT is first registered high. The second window opens when a write is registered while ODT is high, and its length depends on the burst length. ODT may be registered low only once both windows have ended. A later write can push the write window further out. When ODT drops too early, the monitor raises a one-cycle violation pulse and sets a sticky error flag. A saturating counter shows how many more cycles ODT must stay high, which helps with debug.

Both hold lengths are parameters. The default window after the ODT rise is 4 cycles. The default write window is 4 cycles for a short burst and 6 cycles for a long burst.

Top module: `odt_hold_monitor`

## Requirements
- R1: After reset, `hold_left_o` is 0 and both `early_drop_o` and `drop_err_o` are 0. Reset also clears a previously set `drop_err_o`.
- R2: When ODT is sampled high after having been sampled low (or after reset), `hold_left_o` becomes HOLD_BASE-1 (3 by default) on that edge. Absent writes, it then falls by one at each further edge where ODT is sampled high.
- R3: If ODT is sampled low while `hold_left_o` is nonzero, `early_drop_o` is 1 for exactly the one cycle that follows that edge. If ODT is sampled low while `hold_left_o` is 0, no pulse is raised.
- R4: A write sampled with ODT high sets `hold_left_o` to at least HOLD_LONG-1 (5 by default) when `bl8_i`=1, and to at least HOLD_BASE-1 (3) when `bl8_i`=0.
- R5: When the ODT-rise window and a write window overlap, `hold_left_o` follows whichever of the two ends later. A later write with a shorter window never shortens the requirement that is already pending.
- R6: A write sampled while ODT is low opens no window. `hold_left_o` stays 0, and a rise that follows loads only HOLD_BASE-1.
- R7: `drop_err_o` goes to 1 in the same cycle as the first `early_drop_o` pulse. It stays at 1 until reset.
- R8: While ODT remains high, `hold_left_o` saturates at 0 and never wraps.
- R9: `hold_left_o` is 0 in the cycle after any edge at which ODT is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All inputs are sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| odt_i | input | 1 | ODT level as registered at the memory interface. |
| wr_i | input | 1 | Write command registered in this cycle. |
| bl8_i | input | 1 | Burst length of the write: 1 = 8, 0 = 4. |
| early_drop_o | output | 1 | One-cycle pulse when ODT is registered low too early. |
| drop_err_o | output | 1 | Sticky error flag, cleared only by reset. |
| hold_left_o | output | CNT_W | Cycles ODT must still stay high (saturating). |

## Verification
The properties treat every input as a clean synchronous level. They assume `odt_i`, `wr_i` and `bl8_i` are stable at the sampling edge and that `bl8_i` only matters when `wr_i` is 1. They do not assume that ODT stays high, because ODT dropping early is exactly the event the monitor must report. The bench changes inputs only on the falling clock edge. It applies a fresh reset before each scenario, so no scenario inherits a pending window or a set error flag from the one before it.

// File: rtl/odt_mon_pkg.sv
package odt_mon_pkg;

   // One registered interface sample
   typedef struct packed {
      logic odt;
      logic wr;
      logic bl8;
   } odt_sample_t;

   // Width needed to hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/odt_level_tracker.sv
module odt_level_tracker
   import odt_mon_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  odt_sample_t smp_i,
   output logic        rise_o
);

   logic odt_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) odt_prev_q <= 1'b0;
      else        odt_prev_q <= smp_i.odt;
   end

   // First sample high after a low (or after reset)
   assign rise_o = smp_i.odt & ~odt_prev_q;

endmodule

// File: rtl/odt_window_timer.sv
module odt_window_timer
   import odt_mon_pkg::*;
#(
   parameter int unsigned HOLD_BASE = 4,
   parameter int unsigned HOLD_LONG = 6,
   parameter int unsigned CNT_W     = cnt_width(HOLD_LONG)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  odt_sample_t      smp_i,
   input  logic             rise_i,
   output logic [CNT_W-1:0] left_o,
   output logic             early_o
);

   localparam logic [CNT_W-1:0] LEFT_BASE = CNT_W'(HOLD_BASE - 1);
   localparam logic [CNT_W-1:0] LEFT_LONG = CNT_W'(HOLD_LONG - 1);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [CNT_W-1:0] left_q, left_d;
   logic [CNT_W-1:0] carry_left;   // pending requirement moved one cycle on
   logic [CNT_W-1:0] wr_left;      // requirement opened by this write

   // Length of the write window: the mux is dropped when both lengths agree
   generate
      if (HOLD_LONG == HOLD_BASE) begin : g_wr_fixed
         assign wr_left = (smp_i.odt && smp_i.wr) ? LEFT_BASE : '0;
      end else begin : g_wr_by_burst
         assign wr_left = !(smp_i.odt && smp_i.wr) ? '0 :
                          (smp_i.bl8 ? LEFT_LONG : LEFT_BASE);
      end
   endgenerate

   always_comb begin
      if (rise_i)
         carry_left = LEFT_BASE;
      else if (left_q == '0)
         carry_left = '0;
      else
         carry_left = left_q - ONE;

      if (!smp_i.odt)
         left_d = '0;
      else if (wr_left > carry_left)
         left_d = wr_left;
      else
         left_d = carry_left;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left_q <= '0;
      else        left_q <= left_d;
   end

   assign left_o  = left_q;
   assign early_o = ~smp_i.odt & (left_q != '0);

endmodule

// File: rtl/odt_violation_flag.sv
module odt_violation_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic early_i,
   output logic pulse_o,
   output logic sticky_o
);

   logic pulse_q, sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q  <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         pulse_q  <= early_i;
         sticky_q <= sticky_q | early_i;
      end
   end

   assign pulse_o  = pulse_q;
   assign sticky_o = sticky_q;

endmodule

// File: rtl/odt_hold_monitor.sv
module odt_hold_monitor
   import odt_mon_pkg::*;
#(
   parameter int unsigned HOLD_BASE = 4,
   parameter int unsigned HOLD_LONG = 6,
   parameter int unsigned CNT_W     = cnt_width(HOLD_LONG)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             odt_i,
   input  logic             wr_i,
   input  logic             bl8_i,
   output logic             early_drop_o,
   output logic             drop_err_o,
   output logic [CNT_W-1:0] hold_left_o
);

   // Elaboration-time parameter checks
   generate
      if (HOLD_BASE < 2) begin : g_bad_base
         $error("HOLD_BASE must be at least 2");
      end
      if (HOLD_LONG < HOLD_BASE) begin : g_bad_long
         $error("HOLD_LONG must not be shorter than HOLD_BASE");
      end
      if ((1 << CNT_W) <= HOLD_LONG) begin : g_bad_width
         $error("CNT_W too narrow for HOLD_LONG");
      end
   endgenerate

   odt_sample_t smp;
   logic        rise;
   logic        early;

   assign smp.odt = odt_i;
   assign smp.wr  = wr_i;
   assign smp.bl8 = bl8_i;

   odt_level_tracker u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp),
      .rise_o (rise)
   );

   odt_window_timer #(
      .HOLD_BASE (HOLD_BASE),
      .HOLD_LONG (HOLD_LONG),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_i   (smp),
      .rise_i  (rise),
      .left_o  (hold_left_o),
      .early_o (early)
   );

   odt_violation_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .early_i  (early),
      .pulse_o  (early_drop_o),
      .sticky_o (drop_err_o)
   );

endmodule

// File: rtl/odt_hold_monitor_chk.sv
module odt_hold_monitor_chk #(
   parameter int unsigned HOLD_BASE = 4,
   parameter int unsigned HOLD_LONG = 6,
   parameter int unsigned CNT_W     = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             odt_i,
   input logic             wr_i,
   input logic             bl8_i,
   input logic             early_drop_o,
   input logic             drop_err_o,
   input logic [CNT_W-1:0] hold_left_o
);

   localparam logic [CNT_W-1:0] C_BASE = CNT_W'(HOLD_BASE - 1);
   localparam logic [CNT_W-1:0] C_LONG = CNT_W'(HOLD_LONG - 1);

   // Independent record of the last sampled ODT level
   logic seen_high_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_high_q <= 1'b0;
      else        seen_high_q <= odt_i;
   end

   assert_rise_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && !seen_high_q && !wr_i) |=> (hold_left_o == C_BASE));

   assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && !wr_i && hold_left_o != '0) |=>
         (hold_left_o == $past(hold_left_o) - CNT_W'(1)));

   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      early_drop_o |=> !early_drop_o);

   assert_no_pulse_when_met_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!odt_i && hold_left_o == '0) |=> !early_drop_o);

   assert_long_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && wr_i && bl8_i) |=> (hold_left_o >= C_LONG));

   assert_short_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && wr_i && !bl8_i) |=> (hold_left_o >= C_BASE));

   assert_no_shorten_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && hold_left_o != '0) |=> (hold_left_o >= $past(hold_left_o) - CNT_W'(1)));

   assert_low_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!odt_i && wr_i && hold_left_o == '0) |=> (hold_left_o == '0 && !early_drop_o));

   assert_err_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      early_drop_o |-> drop_err_o);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err_o |=> drop_err_o);

   assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (odt_i && seen_high_q && !wr_i && hold_left_o == '0) |=> (hold_left_o == '0));

   assert_low_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !odt_i |=> (hold_left_o == '0));

endmodule

bind odt_hold_monitor odt_hold_monitor_chk #(
   .HOLD_BASE (HOLD_BASE),
   .HOLD_LONG (HOLD_LONG),
   .CNT_W     (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .odt_i        (odt_i),
   .wr_i         (wr_i),
   .bl8_i        (bl8_i),
   .early_drop_o (early_drop_o),
   .drop_err_o   (drop_err_o),
   .hold_left_o  (hold_left_o)
);

// File: tb/odt_hold_monitor_bench.sv
`timescale 1ns/1ps
module odt_hold_monitor_bench;

   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          odt_i = 1'b0;
   logic          wr_i = 1'b0;
   logic          bl8_i = 1'b0;
   logic          early_drop_o;
   logic          drop_err_o;
   logic [CW-1:0] hold_left_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   odt_hold_monitor u_odt_hold_monitor (
      .clk          (clk),
      .rst_n        (rst_n),
      .odt_i        (odt_i),
      .wr_i         (wr_i),
      .bl8_i        (bl8_i),
      .early_drop_o (early_drop_o),
      .drop_err_o   (drop_err_o),
      .hold_left_o  (hold_left_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; odt_i = 1'b0; wr_i = 1'b0; bl8_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive one sample, let it be registered, observe after the edge
   task automatic step(input logic o, input logic w, input logic b);
      @(negedge clk);
      odt_i = o; wr_i = w; bl8_i = b;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      do_reset();
      #1;
      chk("R1 hold_left", int'(hold_left_o), 0);
      chk("R1 early_drop", int'(early_drop_o), 0);
      chk("R1 drop_err", int'(drop_err_o), 0);
   endtask

   task automatic t_rise_hold_met();
      do_reset();
      step(1, 0, 0); chk("R2 load on rise", int'(hold_left_o), 3);
      step(1, 0, 0); chk("R2 count", int'(hold_left_o), 2);
      step(1, 0, 0); chk("R2 count", int'(hold_left_o), 1);
      step(1, 0, 0); chk("R2 count", int'(hold_left_o), 0);
      step(1, 0, 0); chk("R8 saturate", int'(hold_left_o), 0);
      step(1, 0, 0); chk("R8 saturate", int'(hold_left_o), 0);
      step(0, 0, 0);
      chk("R3 no pulse when met", int'(early_drop_o), 0);
      chk("R9 low clears", int'(hold_left_o), 0);
   endtask

   task automatic t_early_drop();
      do_reset();
      step(1, 0, 0);
      step(1, 0, 0);
      step(0, 0, 0);
      chk("R3 pulse", int'(early_drop_o), 1);
      chk("R7 err set", int'(drop_err_o), 1);
      chk("R9 low clears", int'(hold_left_o), 0);
      step(0, 0, 0);
      chk("R3 pulse one cycle", int'(early_drop_o), 0);
      chk("R7 err sticky", int'(drop_err_o), 1);
      step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
      step(0, 0, 0);
      chk("R7 err still set", int'(drop_err_o), 1);
      do_reset();
      #1;
      chk("R1 reset clears err", int'(drop_err_o), 0);
   endtask

   task automatic t_long_write();
      do_reset();
      step(1, 0, 0);
      step(1, 0, 0);
      step(1, 1, 1); chk("R4 long write", int'(hold_left_o), 5);
      for (int i = 4; i >= 0; i--) begin
         step(1, 0, 0);
         chk("R4 long countdown", int'(hold_left_o), i);
      end
      step(0, 0, 0);
      chk("R4 long met no pulse", int'(early_drop_o), 0);
   endtask

   task automatic t_short_write_late();
      do_reset();
      step(1, 0, 0);
      step(1, 0, 0);
      step(1, 0, 0); chk("R2 before write", int'(hold_left_o), 1);
      step(1, 1, 0); chk("R4 short write", int'(hold_left_o), 3);
      step(1, 0, 0);
      step(0, 0, 0);
      chk("R5 write window enforced", int'(early_drop_o), 1);
   endtask

   task automatic t_overlap_keep_later();
      do_reset();
      step(1, 1, 1); chk("R5 rise with long write", int'(hold_left_o), 5);
      step(1, 1, 0); chk("R5 short write no shorten", int'(hold_left_o), 4);
      step(1, 1, 1); chk("R5 long write restarts", int'(hold_left_o), 5);
      step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
      step(0, 0, 0);
      chk("R5 drop one early", int'(early_drop_o), 1);
   endtask

   task automatic t_write_while_low();
      do_reset();
      step(0, 1, 1);
      chk("R6 no window", int'(hold_left_o), 0);
      chk("R6 no pulse", int'(early_drop_o), 0);
      step(1, 0, 0);
      chk("R6 rise loads base only", int'(hold_left_o), 3);
   endtask

   initial begin
      t_reset_state();
      t_rise_hold_met();
      t_early_drop();
      t_long_write();
      t_short_write_late();
      t_overlap_keep_later();
      t_write_while_low();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule